// File: doc/BRIEF.md
# Bus Clock Enable Rate Generator

This block runs on a fast core clock and produces a one-cycle enable pulse that paces a slower bus domain. The bus logic stays on the core clock and advances only on the cycles where the enable is high, so no second clock tree is needed. A single control word sets the rate. In integer mode the enable fires once every N core cycles. In fractional mode a phase accumulator lets through N of every 32 core cycles and spreads those pulses as evenly as the 32-cycle frame allows.

Software writes a new control word at any time. The block holds it as pending and swaps it in only at a pulse boundary of the setting that is running, so the bus domain never sees a shortened or doubled period during a rate change. A busy flag stays high from the write until the swap. The setting in force can be read back.

Top module: `busclk_en_gen`

## Requirements
- R1: While reset is high and on the first cycle after it, tick_o and busy_o are 0 and the readback shows integer mode with value 0.
- R2: In integer mode with value N (1..31), tick_o is high for exactly one cycle out of every N, so consecutive pulses are N cycles apart. N=1 holds tick_o high on every cycle.
- R3: In fractional mode with value N (1..31), any window of 32 consecutive cycles holds exactly N pulses.
- R4: In fractional mode, the gap between consecutive pulses is never shorter than floor(32/N) and never longer than ceil(32/N). For N<=16, two pulses are never adjacent.
- R5: A value of 0 gives no pulses in either mode.
- R6: The control word is cfg_wdata[5:0]. Bit 5 selects the mode (0 = integer, 1 = fractional) and bits [4:0] hold N. The readback reports the mode on cur_mode_o and N on cur_val_o.
- R7: busy_o goes high on the cycle after a write and stays high until the written setting is in force, then drops.
- R8: A pending setting takes over only on a cycle where the running setting emits a pulse, or on the next cycle if the running value is 0. The cycle where busy_o falls carries the last pulse of the old rate. In integer mode the first new pulse follows a full new period after it.
- R9: A second write before the first one takes over replaces it. Only the last written setting ever comes into force.
- R10: The readback changes only at the moment a pending setting comes into force, never while busy_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the control word |
| cfg_wdata | input | 6 | Control word: bit 5 is the mode, bits 4:0 are N |
| tick_o | output | 1 | One-cycle bus enable pulse |
| busy_o | output | 1 | High while a written setting waits to take over |
| cur_mode_o | output | 1 | Mode currently in force (1 = fractional) |
| cur_val_o | output | 5 | Value N currently in force |

## Verification
The hardest case to reach is a rate change in the middle of a run, where the handover must land on the old setting's final pulse and the first new interval must be a complete new period. The stimulus starts integer mode with N=7, lets it run part of a period, and writes N=3. It then checks three things: the readback still shows 7 while busy_o is high, tick_o is high on the cycle where busy_o falls, and the next pulse comes exactly three cycles later. A second sequence writes twice in quick succession behind a long 31-cycle period, so that both writes arrive before a boundary and the replacement rule decides which setting wins.

// File: rtl/busclk_pkg.sv
package busclk_pkg;

  typedef enum logic {
    MODE_INT  = 1'b0,
    MODE_FRAC = 1'b1
  } rate_mode_e;

endpackage

// File: rtl/busclk_int_div.sv
module busclk_int_div #(
  parameter int VAL_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             restart,
  input  logic [VAL_W-1:0] div,
  output logic             hit
);

  logic [VAL_W-1:0] cnt;
  logic [VAL_W-1:0] last;

  assign last = div - {{(VAL_W-1){1'b0}}, 1'b1};
  assign hit  = en && (div != '0) && (cnt == last);

  always_ff @(posedge clk) begin
    if (rst || restart || !en) begin
      cnt <= '0;
    end else if (hit) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + {{(VAL_W-1){1'b0}}, 1'b1};
    end
  end

endmodule

// File: rtl/busclk_frac_acc.sv
module busclk_frac_acc #(
  parameter int VAL_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             restart,
  input  logic [VAL_W-1:0] num,
  output logic             hit
);

  logic [VAL_W-1:0] phase;
  logic [VAL_W:0]   sum;

  assign sum = {1'b0, phase} + {1'b0, num};
  assign hit = en && sum[VAL_W];

  always_ff @(posedge clk) begin
    if (rst || restart || !en) begin
      phase <= '0;
    end else begin
      phase <= sum[VAL_W-1:0];
    end
  end

endmodule

// File: rtl/busclk_cfg_ctrl.sv
module busclk_cfg_ctrl
  import busclk_pkg::*;
#(
  parameter int VAL_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [VAL_W:0]   wdata,
  input  logic             boundary,
  output rate_mode_e       act_mode,
  output logic [VAL_W-1:0] act_val,
  output logic             apply,
  output logic             busy
);

  rate_mode_e       pend_mode;
  logic [VAL_W-1:0] pend_val;
  logic             pend_vld;

  assign apply = pend_vld && boundary;
  assign busy  = pend_vld;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_mode <= MODE_INT;
      pend_val  <= '0;
      pend_vld  <= 1'b0;
    end else if (we) begin
      pend_mode <= rate_mode_e'(wdata[VAL_W]);
      pend_val  <= wdata[VAL_W-1:0];
      pend_vld  <= 1'b1;
    end else if (apply) begin
      pend_vld  <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_mode <= MODE_INT;
      act_val  <= '0;
    end else if (apply) begin
      act_mode <= pend_mode;
      act_val  <= pend_val;
    end
  end

endmodule

// File: rtl/busclk_en_gen.sv
module busclk_en_gen
  import busclk_pkg::*;
#(
  parameter int VAL_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [VAL_W:0]   cfg_wdata,
  output logic             tick_o,
  output logic             busy_o,
  output logic             cur_mode_o,
  output logic [VAL_W-1:0] cur_val_o
);

  rate_mode_e       act_mode;
  logic [VAL_W-1:0] act_val;
  logic             apply;
  logic             busy;
  logic             int_hit;
  logic             frac_hit;
  logic             sel_hit;
  logic             boundary;
  logic             tick_q;

  busclk_cfg_ctrl #(.VAL_W(VAL_W)) u_cfg (
    .clk      (clk),
    .rst      (rst),
    .we       (cfg_we),
    .wdata    (cfg_wdata),
    .boundary (boundary),
    .act_mode (act_mode),
    .act_val  (act_val),
    .apply    (apply),
    .busy     (busy)
  );

  busclk_int_div #(.VAL_W(VAL_W)) u_int (
    .clk     (clk),
    .rst     (rst),
    .en      (act_mode == MODE_INT),
    .restart (apply),
    .div     (act_val),
    .hit     (int_hit)
  );

  busclk_frac_acc #(.VAL_W(VAL_W)) u_frac (
    .clk     (clk),
    .rst     (rst),
    .en      (act_mode == MODE_FRAC),
    .restart (apply),
    .num     (act_val),
    .hit     (frac_hit)
  );

  assign sel_hit  = (act_mode == MODE_FRAC) ? frac_hit : int_hit;
  assign boundary = sel_hit || (act_val == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      tick_q <= 1'b0;
    end else begin
      tick_q <= sel_hit;
    end
  end

  assign tick_o     = tick_q;
  assign busy_o     = busy;
  assign cur_mode_o = act_mode;
  assign cur_val_o  = act_val;

endmodule

// File: rtl/busclk_en_gen_chk.sv
module busclk_en_gen_chk #(
  parameter int VAL_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_we,
  input logic [VAL_W:0]   cfg_wdata,
  input logic             tick_o,
  input logic             busy_o,
  input logic             cur_mode_o,
  input logic [VAL_W-1:0] cur_val_o
);

  localparam int HALF = 1 << (VAL_W - 1);

  a_r1_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> (!tick_o && !busy_o && cur_val_o == '0));

  a_r2_int_single: assert property (@(posedge clk) disable iff (rst)
    (tick_o && !cur_mode_o && cur_val_o > 1) |=> !tick_o);

  a_r4_frac_spread: assert property (@(posedge clk) disable iff (rst)
    (tick_o && cur_mode_o && cur_val_o != '0 && cur_val_o <= HALF) |=> !tick_o);

  a_r5_zero_quiet: assert property (@(posedge clk) disable iff (rst)
    (cur_val_o == '0) |=> !tick_o);

  a_r7_busy_on_write: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> busy_o);

  a_r8_swap_on_tick: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> (tick_o || $past(cur_val_o) == '0));

  a_r10_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    !busy_o |=> ($stable(cur_mode_o) && $stable(cur_val_o)));

endmodule

bind busclk_en_gen busclk_en_gen_chk #(.VAL_W(VAL_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cfg_we     (cfg_we),
  .cfg_wdata  (cfg_wdata),
  .tick_o     (tick_o),
  .busy_o     (busy_o),
  .cur_mode_o (cur_mode_o),
  .cur_val_o  (cur_val_o)
);

// File: tb/busclk_en_gen_test.sv
`timescale 1ns/1ps
module busclk_en_gen_test;

  localparam int VAL_W = 5;
  localparam int FRAME = 1 << VAL_W;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             cfg_we = 1'b0;
  logic [VAL_W:0]   cfg_wdata = '0;
  logic             tick_o;
  logic             busy_o;
  logic             cur_mode_o;
  logic [VAL_W-1:0] cur_val_o;

  int n_chk = 0;
  int n_bad = 0;

  busclk_en_gen #(.VAL_W(VAL_W)) uut (
    .clk        (clk),
    .rst        (rst),
    .cfg_we     (cfg_we),
    .cfg_wdata  (cfg_wdata),
    .tick_o     (tick_o),
    .busy_o     (busy_o),
    .cur_mode_o (cur_mode_o),
    .cur_val_o  (cur_val_o)
  );

  always #2.5 clk = ~clk;

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  task automatic write_cfg(input bit mode, input int val);
    cfg_wdata = {mode, val[VAL_W-1:0]};
    cfg_we = 1'b1;
    step();
    cfg_we = 1'b0;
    chk(busy_o == 1'b1, "R7 busy after write", int'(busy_o), 1);
  endtask

  task automatic wait_apply(input bit old_running);
    int waited = 0;
    while (busy_o && waited < 100) begin
      step();
      waited++;
    end
    chk(busy_o == 1'b0, "R7 busy clears", int'(busy_o), 0);
    if (old_running)
      chk(tick_o == 1'b1, "R8 swap on last old pulse", int'(tick_o), 1);
  endtask

  task automatic check_readback(input bit mode, input int val, input string req);
    chk(cur_mode_o == mode, req, int'(cur_mode_o), int'(mode));
    chk(int'(cur_val_o) == val, req, int'(cur_val_o), val);
  endtask

  task automatic measure_period(input int exp, input string req);
    int k = 0;
    do begin
      step();
      k++;
    end while (!tick_o && k < 64);
    chk(k == exp, req, k, exp);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) step();
    chk(!tick_o && !busy_o, "R1 outputs in reset", int'({tick_o, busy_o}), 0);
    check_readback(1'b0, 0, "R1 readback in reset");
    rst = 1'b0;
    step();
    chk(!tick_o && !busy_o, "R1 outputs after reset", int'({tick_o, busy_o}), 0);
  endtask

  task automatic t_integer(input int n, input bit old_running);
    write_cfg(1'b0, n);
    wait_apply(old_running);
    check_readback(1'b0, n, "R6 integer readback");
    measure_period(n, "R8 first new integer period");
    for (int p = 0; p < 3; p++) measure_period(n, "R2 integer period");
  endtask

  task automatic t_frac(input int n, input bit old_running);
    int cnt = 0;
    int last = -1;
    int gmin = 1000;
    int gmax = 0;
    write_cfg(1'b1, n);
    wait_apply(old_running);
    check_readback(1'b1, n, "R6 fractional readback");
    for (int c = 0; c < 2 * FRAME; c++) begin
      step();
      if (tick_o) begin
        cnt++;
        if (last >= 0) begin
          if (c - last < gmin) gmin = c - last;
          if (c - last > gmax) gmax = c - last;
        end
        last = c;
      end
    end
    chk(cnt == 2 * n, "R3 pulses per two frames", cnt, 2 * n);
    chk(gmin >= FRAME / n, "R4 shortest gap", gmin, FRAME / n);
    chk(gmax <= (FRAME + n - 1) / n, "R4 longest gap", gmax, (FRAME + n - 1) / n);
  endtask

  task automatic t_zero(input bit mode, input bit old_running);
    int cnt = 0;
    write_cfg(mode, 0);
    wait_apply(old_running);
    check_readback(mode, 0, "R6 zero readback");
    for (int c = 0; c < 2 * FRAME; c++) begin
      step();
      if (tick_o) cnt++;
    end
    chk(cnt == 0, "R5 no pulses at zero", cnt, 0);
  endtask

  task automatic t_midrun_change();
    t_integer(7, 1'b0);
    step();
    step();
    write_cfg(1'b0, 3);
    check_readback(1'b0, 7, "R10 old setting held while pending");
    wait_apply(1'b1);
    check_readback(1'b0, 3, "R8 new setting in force");
    measure_period(3, "R8 full first period after change");
    measure_period(3, "R2 period after change");
  endtask

  task automatic t_replace();
    write_cfg(1'b0, 31);
    wait_apply(1'b0);
    step();
    write_cfg(1'b0, 9);
    write_cfg(1'b0, 12);
    check_readback(1'b0, 31, "R10 readback before swap");
    wait_apply(1'b1);
    check_readback(1'b0, 12, "R9 last write wins");
    measure_period(12, "R9 period of last write");
    measure_period(12, "R9 period of last write");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    t_reset();
    t_integer(1, 1'b0);
    t_integer(2, 1'b1);
    t_integer(5, 1'b1);
    t_integer(31, 1'b1);
    t_frac(1, 1'b1);
    t_frac(5, 1'b1);
    t_frac(16, 1'b1);
    t_frac(17, 1'b1);
    t_frac(31, 1'b1);
    t_zero(1'b0, 1'b1);
    t_zero(1'b1, 1'b0);
    t_midrun_change();
    t_integer(4, 1'b1);
    t_frac(5, 1'b1);
    t_integer(4, 1'b1);
    t_replace();
    summary();
    $finish;
  end

endmodule